// File: doc/BRIEF.md
# Trigger Sequence Consistency Checker

This block observes a stream of trigger accepts. Each accept arrives with a 32-bit event identifier, a local bunch-crossing number and one parity bit. The block checks every accept for a bad identifier parity, an identifier that breaks the expected count sequence, a crossing number outside the legal range, and a crossing number that differs from the one it predicts. It keeps a packed history of recent error codes, snapshots of the last good identifier, the last bad identifier and the identifier it expected, a crossing error snapshot, and four saturating error counters. A host reads all of these in parallel, with no handshake.

The identifier has two parts. The top 8 bits hold an extension byte that advances on each event-counter-reset strobe. The low 24 bits hold the running accept count. Expectations are held by a two-state controller. In `ST_UNSEEDED`, reached by the CLEAR transition on reset, the controller predicts nothing. The SEED transition moves it to `ST_TRACKING` on the first accept. From then on the predicted identifier is updated on every accept and every counter-reset strobe. The predicted crossing number advances once per clock and wraps after 3563.

Top module: `trig_timing_checker`

## Requirements
- R1: A one-cycle reset pulse (`rst` high at a clock edge) clears the error history, all four snapshots and all four counters to zero, and returns the controller to the unseeded state.
- R2: An accept is an identifier parity error when `evt_id` together with `id_parity` holds an even number of ones. Each such accept increments `cnt_id_parity` and records code 1.
- R3: The first accept after reset seeds the identifier and crossing predictions. It never raises an identifier mismatch (code 2) or a crossing mismatch (code 4).
- R4: Once seeded, an accept whose `evt_id` differs from the prediction increments `cnt_id_mismatch` and records code 2. After an accept without a parity error, the prediction becomes the received extension byte with the received 24-bit count plus one. After an accept with a parity error, the prediction becomes the old prediction's count plus one.
- R5: An event-counter-reset strobe sets the predicted 24-bit count to zero and the predicted extension byte to its current value plus one, modulo 256. When the strobe coincides with an accept, the accept is checked against the old prediction and the strobe then acts on the prediction that accept produced.
- R6: An accept whose `bx_local` is above 3563 increments `cnt_bx_range` and records code 3.
- R7: Once seeded, the predicted crossing number advances by one every clock and wraps from 3563 to 0. A seeded accept whose `bx_local` differs from it increments `cnt_bx_mismatch` and records code 4. On code 3 or code 4, `bx_snap` takes the received number in bits 27:16 and the predicted number in bits 11:0, with all other bits zero.
- R8: `err_hist` holds the last eight recorded codes in 4-bit slots. Each erroneous accept shifts the word left by four bits and places its code in bits 3:0, which drops the oldest code. An accept with no error leaves the word unchanged.
- R9: When one accept has several errors, each applicable counter increments and only the lowest code is written to the history.
- R10: An accept with no error of any kind copies `evt_id` into `last_good`. An accept with an identifier parity error or an identifier mismatch copies `evt_id` into `last_bad` and the prediction into `exp_snap`.
- R11: Every counter stops at all-ones and stays there until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset pulse, active high |
| accept | input | 1 | Trigger accept strobe |
| ctr_reset | input | 1 | Event-counter-reset strobe |
| evt_id | input | 32 | Extension byte (31:24) and accept count (23:0) |
| bx_local | input | 12 | Local bunch-crossing number |
| id_parity | input | 1 | Odd parity bit over `evt_id` |
| err_hist | output | 32 | Last eight 4-bit error codes, newest in bits 3:0 |
| last_good | output | 32 | Identifier of the last error-free accept |
| last_bad | output | 32 | Identifier of the last accept with an identifier error |
| exp_snap | output | 32 | Predicted identifier at the last identifier error |
| bx_snap | output | 32 | Received (27:16) and predicted (11:0) crossing at the last crossing error |
| cnt_id_parity | output | CNT_W (32) | Identifier parity error count |
| cnt_id_mismatch | output | CNT_W (32) | Identifier mismatch count |
| cnt_bx_range | output | CNT_W (32) | Out-of-range crossing count |
| cnt_bx_mismatch | output | CNT_W (32) | Crossing mismatch count |

## Verification
A wrong prediction inside the controller shows up at the next seeded accept. It appears as a spurious code 2 or code 4 in `err_hist`, as a counter step, and as the prediction itself in `exp_snap` or `bx_snap`, all one clock after that accept. A crossing prediction that has drifted cannot go unseen for longer than the gap between two accepts. The bench therefore places accepts on both sides of the 3563 wrap and after idle stretches. A controller that seeds too late or never seeds shows up on the second accept after reset, as a missing or spurious mismatch.

// File: rtl/trig_chk_pkg.sv
package trig_chk_pkg;

    localparam int CODE_W = 4;

    typedef enum logic [CODE_W-1:0] {
        CODE_NONE     = 4'd0,
        CODE_ID_PAR   = 4'd1,
        CODE_ID_MIS   = 4'd2,
        CODE_BX_RANGE = 4'd3,
        CODE_BX_MIS   = 4'd4
    } err_code_t;

    typedef enum logic [0:0] {
        ST_UNSEEDED = 1'b0,
        ST_TRACKING = 1'b1
    } trk_state_t;

    // flag vector positions
    localparam int F_ID_PAR   = 0;
    localparam int F_ID_MIS   = 1;
    localparam int F_BX_RANGE = 2;
    localparam int F_BX_MIS   = 3;
    localparam int N_FLAGS    = 4;

endpackage

// File: rtl/trig_err_classify.sv
module trig_err_classify
    import trig_chk_pkg::*;
#(
    parameter int EXT_W   = 8,
    parameter int ACC_W   = 24,
    parameter int BX_W    = 12,
    parameter int BX_LAST = 3563
) (
    input  logic                   accept,
    input  logic                   seeded,
    input  logic [EXT_W+ACC_W-1:0] evt_id,
    input  logic                   id_parity,
    input  logic [BX_W-1:0]        bx_local,
    input  logic [EXT_W+ACC_W-1:0] exp_id,
    input  logic [BX_W-1:0]        exp_bx,
    output logic [N_FLAGS-1:0]     err_flags,
    output err_code_t              err_code
);
    localparam logic [BX_W-1:0] BX_LAST_V = BX_W'(BX_LAST);

    always_comb begin
        err_flags             = '0;
        // odd parity expected over identifier plus parity bit
        err_flags[F_ID_PAR]   = accept && !(^{evt_id, id_parity});
        err_flags[F_ID_MIS]   = accept && seeded && (evt_id != exp_id);
        err_flags[F_BX_RANGE] = accept && (bx_local > BX_LAST_V);
        err_flags[F_BX_MIS]   = accept && seeded && (bx_local != exp_bx);
    end

    // lowest code wins when several errors coincide
    always_comb begin
        if (err_flags[F_ID_PAR])
            err_code = CODE_ID_PAR;
        else if (err_flags[F_ID_MIS])
            err_code = CODE_ID_MIS;
        else if (err_flags[F_BX_RANGE])
            err_code = CODE_BX_RANGE;
        else if (err_flags[F_BX_MIS])
            err_code = CODE_BX_MIS;
        else
            err_code = CODE_NONE;
    end

endmodule

// File: rtl/trig_seq_tracker.sv
module trig_seq_tracker
    import trig_chk_pkg::*;
#(
    parameter int EXT_W   = 8,
    parameter int ACC_W   = 24,
    parameter int BX_W    = 12,
    parameter int BX_LAST = 3563
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   accept,
    input  logic                   ctr_reset,
    input  logic [EXT_W+ACC_W-1:0] evt_id,
    input  logic [BX_W-1:0]        bx_local,
    input  logic                   id_par_err,
    output logic                   seeded,
    output logic [EXT_W+ACC_W-1:0] exp_id,
    output logic [BX_W-1:0]        exp_bx
);
    localparam int ID_W = EXT_W + ACC_W;
    localparam logic [BX_W-1:0] BX_LAST_V = BX_W'(BX_LAST);

    trk_state_t state_q, state_d;

    logic [EXT_W-1:0] base_ext;
    logic [ACC_W-1:0] base_acc;
    logic [ID_W-1:0]  exp_id_d;
    logic [BX_W-1:0]  exp_bx_d;

    function automatic logic [BX_W-1:0] bx_step(input logic [BX_W-1:0] v);
        return (v >= BX_LAST_V) ? '0 : v + 1'b1;
    endfunction

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_UNSEEDED;
        else
            state_q <= state_d;
    end

    // transitions: SEED on the first accept, CLEAR only through reset
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_UNSEEDED: if (accept) state_d = ST_TRACKING;
            ST_TRACKING: state_d = ST_TRACKING;
            default:     state_d = ST_UNSEEDED;
        endcase
    end

    // prediction outputs of each state
    always_comb begin
        base_ext = exp_id[ID_W-1:ACC_W];
        base_acc = exp_id[ACC_W-1:0];
        exp_bx_d = exp_bx;
        unique case (state_q)
            ST_UNSEEDED: begin
                if (accept) begin
                    base_ext = evt_id[ID_W-1:ACC_W];
                    base_acc = evt_id[ACC_W-1:0] + 1'b1;
                    exp_bx_d = bx_step(bx_local);
                end
            end
            ST_TRACKING: begin
                exp_bx_d = bx_step(exp_bx);
                if (accept) begin
                    if (id_par_err) begin
                        base_acc = exp_id[ACC_W-1:0] + 1'b1;
                    end else begin
                        base_ext = evt_id[ID_W-1:ACC_W];
                        base_acc = evt_id[ACC_W-1:0] + 1'b1;
                    end
                end
            end
            default: ;
        endcase
        if (ctr_reset)
            exp_id_d = {base_ext + 1'b1, {ACC_W{1'b0}}};
        else
            exp_id_d = {base_ext, base_acc};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_id <= '0;
            exp_bx <= '0;
        end else begin
            exp_id <= exp_id_d;
            exp_bx <= exp_bx_d;
        end
    end

    assign seeded = (state_q == ST_TRACKING);

    a_r3_seed_on_first_accept: assert property (@(posedge clk) disable iff (rst)
        (!seeded && accept) |=> seeded);

    a_r7_predicted_bx_in_range: assert property (@(posedge clk) disable iff (rst)
        seeded |-> (exp_bx <= BX_LAST_V));

    a_r5_ctr_reset_zeroes_count: assert property (@(posedge clk) disable iff (rst)
        ctr_reset |=> (exp_id[ACC_W-1:0] == '0));

endmodule

// File: rtl/trig_sat_counter.sv
module trig_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (inc && (q != TOP))
            q <= q + 1'b1;
    end

    a_r11_hold_at_top: assert property (@(posedge clk) disable iff (rst)
        (q == TOP) |=> (q == TOP));

    a_r11_still_without_inc: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(q));

endmodule

// File: rtl/trig_timing_checker.sv
module trig_timing_checker
    import trig_chk_pkg::*;
#(
    parameter int EXT_W      = 8,
    parameter int ACC_W      = 24,
    parameter int BX_W       = 12,
    parameter int BX_LAST    = 3563,
    parameter int HIST_DEPTH = 8,
    parameter int CNT_W      = 32
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           accept,
    input  logic                           ctr_reset,
    input  logic [EXT_W+ACC_W-1:0]         evt_id,
    input  logic [BX_W-1:0]                bx_local,
    input  logic                           id_parity,
    output logic [HIST_DEPTH*CODE_W-1:0]   err_hist,
    output logic [EXT_W+ACC_W-1:0]         last_good,
    output logic [EXT_W+ACC_W-1:0]         last_bad,
    output logic [EXT_W+ACC_W-1:0]         exp_snap,
    output logic [2*(BX_W+4)-1:0]          bx_snap,
    output logic [CNT_W-1:0]               cnt_id_parity,
    output logic [CNT_W-1:0]               cnt_id_mismatch,
    output logic [CNT_W-1:0]               cnt_bx_range,
    output logic [CNT_W-1:0]               cnt_bx_mismatch
);
    localparam int ID_W   = EXT_W + ACC_W;
    localparam int HIST_W = HIST_DEPTH * CODE_W;
    localparam int BX_PAD = 4;

    logic                seeded;
    logic [ID_W-1:0]     exp_id;
    logic [BX_W-1:0]     exp_bx;
    logic [N_FLAGS-1:0]  err_flags;
    err_code_t           err_code;
    logic [CNT_W-1:0]    cnt_q [N_FLAGS];

    trig_err_classify #(
        .EXT_W(EXT_W), .ACC_W(ACC_W), .BX_W(BX_W), .BX_LAST(BX_LAST)
    ) u_classify (
        .accept    (accept),
        .seeded    (seeded),
        .evt_id    (evt_id),
        .id_parity (id_parity),
        .bx_local  (bx_local),
        .exp_id    (exp_id),
        .exp_bx    (exp_bx),
        .err_flags (err_flags),
        .err_code  (err_code)
    );

    trig_seq_tracker #(
        .EXT_W(EXT_W), .ACC_W(ACC_W), .BX_W(BX_W), .BX_LAST(BX_LAST)
    ) u_tracker (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .ctr_reset  (ctr_reset),
        .evt_id     (evt_id),
        .bx_local   (bx_local),
        .id_par_err (err_flags[F_ID_PAR]),
        .seeded     (seeded),
        .exp_id     (exp_id),
        .exp_bx     (exp_bx)
    );

    for (genvar g = 0; g < N_FLAGS; g++) begin : g_cnt
        trig_sat_counter #(.W(CNT_W)) u_cnt (
            .clk (clk),
            .rst (rst),
            .inc (err_flags[g]),
            .q   (cnt_q[g])
        );
    end

    assign cnt_id_parity   = cnt_q[F_ID_PAR];
    assign cnt_id_mismatch = cnt_q[F_ID_MIS];
    assign cnt_bx_range    = cnt_q[F_BX_RANGE];
    assign cnt_bx_mismatch = cnt_q[F_BX_MIS];

    // history and snapshots
    always_ff @(posedge clk) begin
        if (rst) begin
            err_hist  <= '0;
            last_good <= '0;
            last_bad  <= '0;
            exp_snap  <= '0;
            bx_snap   <= '0;
        end else if (accept) begin
            if (err_code != CODE_NONE)
                err_hist <= {err_hist[HIST_W-CODE_W-1:0], err_code};
            if (err_flags == '0)
                last_good <= evt_id;
            if (err_flags[F_ID_PAR] || err_flags[F_ID_MIS]) begin
                last_bad <= evt_id;
                exp_snap <= exp_id;
            end
            if (err_flags[F_BX_RANGE] || err_flags[F_BX_MIS])
                bx_snap <= {{BX_PAD{1'b0}}, bx_local, {BX_PAD{1'b0}}, exp_bx};
        end
    end

    a_r8_hist_quiet_without_accept: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(err_hist));

    a_r8_newest_slot_filled: assert property (@(posedge clk) disable iff (rst)
        (accept && (err_flags != '0)) |=> (err_hist[CODE_W-1:0] != '0));

    a_r10_good_quiet_without_accept: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(last_good));

endmodule

// File: tb/trig_timing_checker_test.sv
module trig_timing_checker_test;

    localparam int CW      = 4;
    localparam int BX_LAST = 3563;

    typedef struct {
        string       tag;
        logic [31:0] hist;
        logic [31:0] good;
        logic [31:0] bad;
        logic [31:0] exps;
        logic [31:0] bxs;
        logic [CW-1:0] c0, c1, c2, c3;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic accept = 1'b0;
    logic ctr_reset = 1'b0;
    logic [31:0] evt_id = '0;
    logic [11:0] bx_local = '0;
    logic id_parity = 1'b0;

    logic [31:0] err_hist, last_good, last_bad, exp_snap, bx_snap;
    logic [CW-1:0] cnt_id_parity, cnt_id_mismatch, cnt_bx_range, cnt_bx_mismatch;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    item_t sb[$];

    // reference model state
    bit          m_seeded;
    logic [31:0] m_exp;
    logic [31:0] m_hist, m_good, m_bad, m_exps, m_bxs;
    logic [CW-1:0] m_c [4];
    logic [11:0] tb_bx = '0;

    always #4 clk = ~clk;

    trig_timing_checker #(.CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .accept(accept), .ctr_reset(ctr_reset),
        .evt_id(evt_id), .bx_local(bx_local), .id_parity(id_parity),
        .err_hist(err_hist), .last_good(last_good), .last_bad(last_bad),
        .exp_snap(exp_snap), .bx_snap(bx_snap),
        .cnt_id_parity(cnt_id_parity), .cnt_id_mismatch(cnt_id_mismatch),
        .cnt_bx_range(cnt_bx_range), .cnt_bx_mismatch(cnt_bx_mismatch)
    );

    function automatic logic [11:0] bx_wrap(input logic [11:0] v);
        return (v >= 12'(BX_LAST)) ? 12'd0 : v + 12'd1;
    endfunction

    function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
        return (v == {CW{1'b1}}) ? v : v + 1'b1;
    endfunction

    task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_seeded = 0; m_exp = '0; m_hist = '0; m_good = '0; m_bad = '0;
        m_exps = '0; m_bxs = '0;
        for (int i = 0; i < 4; i++) m_c[i] = '0;
    endtask

    // one clock of stimulus; pushes the expected outputs when an accept is driven
    task automatic step(input string tag, input bit acc, input bit ctr, input logic [31:0] id,
                        input bit par_ok, input bit ovr, input logic [11:0] ovr_bx);
        bit pe, im, br, bm;
        logic [3:0] code;
        logic [7:0] ext;
        logic [23:0] cnt;
        logic [11:0] bxv;
        item_t it;
        @(negedge clk);
        bxv = ovr ? ovr_bx : tb_bx;
        accept = acc; ctr_reset = ctr; evt_id = id; bx_local = bxv;
        id_parity = par_ok ? ~(^id) : (^id);
        ext = m_exp[31:24]; cnt = m_exp[23:0];
        if (acc) begin
            pe = !par_ok;
            im = m_seeded && (id != m_exp);
            br = bxv > 12'(BX_LAST);
            bm = m_seeded && (bxv != tb_bx);
            code = pe ? 4'd1 : im ? 4'd2 : br ? 4'd3 : bm ? 4'd4 : 4'd0;
            if (pe) m_c[0] = sat_inc(m_c[0]);
            if (im) m_c[1] = sat_inc(m_c[1]);
            if (br) m_c[2] = sat_inc(m_c[2]);
            if (bm) m_c[3] = sat_inc(m_c[3]);
            if (code != 0) m_hist = {m_hist[27:0], code};
            if (!(pe || im || br || bm)) m_good = id;
            if (pe || im) begin m_bad = id; m_exps = m_exp; end
            if (br || bm) m_bxs = {4'b0, bxv, 4'b0, (m_seeded ? tb_bx : 12'd0)};
            if (m_seeded && pe) cnt = m_exp[23:0] + 24'd1;
            else begin ext = id[31:24]; cnt = id[23:0] + 24'd1; end
            m_seeded = 1;
        end
        if (ctr) begin ext = ext + 8'd1; cnt = '0; end
        m_exp = {ext, cnt};
        if (acc) begin
            it.tag = tag; it.hist = m_hist; it.good = m_good; it.bad = m_bad;
            it.exps = m_exps; it.bxs = m_bxs;
            it.c0 = m_c[0]; it.c1 = m_c[1]; it.c2 = m_c[2]; it.c3 = m_c[3];
            sb.push_back(it);
        end
        tb_bx = bx_wrap(tb_bx);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step("", 0, 0, '0, 1, 0, '0);
    endtask

    task automatic good_acc(input string tag, input logic [31:0] id);
        step(tag, 1, 0, id, 1, 0, '0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; accept = 0; ctr_reset = 0;
        bx_local = tb_bx; tb_bx = bx_wrap(tb_bx);
        @(negedge clk);
        rst = 0;
        model_reset();
        // R1: every output cleared
        tests++;
        cmp("R1", "err_hist", err_hist, '0);
        cmp("R1", "last_good", last_good, '0);
        cmp("R1", "last_bad", last_bad, '0);
        cmp("R1", "exp_snap", exp_snap, '0);
        cmp("R1", "bx_snap", bx_snap, '0);
        cmp("R1", "counters", {16'd0, cnt_id_parity, cnt_id_mismatch, cnt_bx_range, cnt_bx_mismatch}, '0);
        bx_local = tb_bx; tb_bx = bx_wrap(tb_bx);
    endtask

    // scoreboard monitor
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            item_t e;
            int f0;
            e = sb.pop_front();
            f0 = fails;
            tests++;
            cmp(e.tag, "err_hist", err_hist, e.hist);
            cmp(e.tag, "last_good", last_good, e.good);
            cmp(e.tag, "last_bad", last_bad, e.bad);
            cmp(e.tag, "exp_snap", exp_snap, e.exps);
            cmp(e.tag, "bx_snap", bx_snap, e.bxs);
            cmp(e.tag, "cnt_id_parity", 32'(cnt_id_parity), 32'(e.c0));
            cmp(e.tag, "cnt_id_mismatch", 32'(cnt_id_mismatch), 32'(e.c1));
            cmp(e.tag, "cnt_bx_range", 32'(cnt_bx_range), 32'(e.c2));
            cmp(e.tag, "cnt_bx_mismatch", 32'(cnt_bx_mismatch), 32'(e.c3));
            if (fails > f0) fails = f0 + 1;
        end
    end

    initial begin
        model_reset();
        repeat (2) @(negedge clk);
        do_reset();

        good_acc("R3", 32'h0500_0010);              // seeds, no mismatch
        good_acc("R10", 32'h0500_0011);             // in sequence
        idle(3);
        good_acc("R4", 32'h0500_0020);              // skipped count
        step("R2", 1, 0, 32'h0500_0021, 0, 0, '0);  // bad parity
        good_acc("R4", 32'h0500_0022);              // prediction advanced past parity error

        step("", 0, 1, '0, 1, 0, '0);               // counter reset alone
        good_acc("R5", 32'h0600_0000);
        step("R5", 1, 1, 32'h0600_0001, 1, 0, '0); // accept with counter reset
        good_acc("R5", 32'h0700_0000);

        step("R7", 1, 0, 32'h0700_0001, 1, 1, 12'd100);   // wrong crossing
        step("R6", 1, 0, 32'h0700_0002, 1, 1, 12'd4000);  // out of range, also R9
        step("R9", 1, 0, 32'h0700_0099, 0, 0, '0);        // parity and id errors together
        good_acc("R10", 32'h0700_009A);

        while (tb_bx != 12'd3562) idle(1);
        good_acc("R7", 32'h0700_009B);              // crossing 3562
        good_acc("R7", 32'h0700_009C);              // crossing 3563
        good_acc("R7", 32'h0700_009D);              // wrapped to 0

        for (int i = 0; i < 4; i++) step("R8", 1, 0, m_exp, 0, 0, '0);
        for (int i = 0; i < 14; i++) step("R11", 1, 0, m_exp, 0, 0, '0);
        idle(2);

        do_reset();
        good_acc("R3", 32'h1234_5678);              // unrelated id after reset: no mismatch
        good_acc("R4", 32'h1234_5679);
        idle(3);
        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (200000) @(posedge clk);
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule